// File: doc/BRIEF.md
# Key-Protected Control Register Bank

This block is a bank of 32-bit control words reached by word address over a plain request strobe. The lowest word holds an unlock flag. Writing the unlock constant to that word opens the rest of the bank for writes. Writing any other value closes it again. While the bank is closed, only the unlock word accepts writes.

The bank holds several kinds of word. Some are plain storage. Some set bits on write and have a clear alias one word higher. Strap words take their start value from input pins and can be frozen by a lock word two positions higher. Some words are read-only identity values. One word yields a fresh pseudo-random value, drawn from a 32-bit LFSR, on every read. Three PLL words always report their lock bit as set.

Every request gets a registered response one cycle later. The response carries the read data and an error flag.

Top module: `key_ctrl_bank`

## Requirements
- R1: A write to word 0 stores 1 when the data equals MAGIC (default 32'h1688A8A8) and stores 0 for any other data. Word 0 accepts writes even while the bank is closed. Word 0 reads back that single bit.
- R2: While word 0 holds 0, a write to any word above 0 changes nothing in the bank.
- R3: Words 4 and 6 are set-type. A write ORs the data into the stored value.
- R4: Words 5 and 7 are clear aliases of words 4 and 6. A write clears every bit of the paired word that is 1 in the data. A clear alias reads as 0.
- R5: Words 8 and 12 are strap words, and words 10 and 14 are their lock words. A strap write ORs the data into the strap, but only while its lock word is zero. The clear alias (words 9 and 13) clears strap bits whether or not the strap is locked.
- R6: Words 1, 2, 3 and 15 are read-only. A write to them leaves their contents unchanged and returns rsp_err=1.
- R7: Every read of word 15 returns the next state of a right-shifting Galois LFSR with tap mask 32'h80200003, starting from SEED (default 1). The step is: shift right by one, then XOR the mask if the old bit 0 was 1. Reset restarts the sequence. Writes do not disturb it.
- R8: Words 16, 17 and 18 store writes as given, but always read back with bit 31 set to 1.
- R9: A request to a word at or above NUM_REGS (default 32) reads 0, drops any write, and returns rsp_err=1.
- R10: Reset loads the following values:
  - word 0 from key_init;
  - words 1 and 2 from rev_a_init and rev_b_init;
  - words 8 and 12 from strap0_init and strap1_init;
  - word 3 from CHIP_ID (default 32'h2A5C0001);
  - word 4 with 32'h0000FF0F and word 6 with 32'hFFFF0000;
  - every other word with 0.
- R11: rsp_valid is high exactly in the cycle after each request. rsp_rdata is 0 for writes. rsp_err is 0 except in the cases named in R6 and R9.
- R12: Words 10, 11, 14 and 19 through NUM_REGS-1 store written data as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_init | input | 1 | Unlock flag loaded at reset |
| rev_a_init | input | 32 | Revision word loaded into word 1 |
| rev_b_init | input | 32 | Revision word loaded into word 2 |
| strap0_init | input | 32 | Strap value loaded into word 8 |
| strap1_init | input | 32 | Strap value loaded into word 12 |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| rsp_err | output | 1 | Out-of-range or read-only-write flag |

## Verification
The assertions assume the following about the inputs:
- At most one request arrives per cycle.
- req_addr and req_wdata are known whenever req_valid is high.
- Reset is applied before the first request.

Several properties compare a stored word with $past of the address and data, so they also rely on each request lasting exactly one cycle. The bench honours all of this by driving each request for a single cycle from the falling edge, holding the inputs idle between requests, and pulsing reset only while no request is in flight.

// File: rtl/keybank_pkg.sv
package keybank_pkg;

  typedef enum logic [3:0] {
    RK_PLAIN, RK_KEY, RK_RO, RK_SET, RK_CLR,
    RK_STRAP, RK_STRAP_CLR, RK_RAND, RK_PLL
  } reg_kind_e;

  localparam int unsigned W_KEY    = 0;
  localparam int unsigned W_REV_A  = 1;
  localparam int unsigned W_REV_B  = 2;
  localparam int unsigned W_CHIP   = 3;
  localparam int unsigned W_RST    = 4;
  localparam int unsigned W_CLK    = 6;
  localparam int unsigned W_STRAP0 = 8;
  localparam int unsigned W_STRAP1 = 12;
  localparam int unsigned W_RAND   = 15;
  localparam int unsigned W_PLL0   = 16;
  localparam int unsigned PLL_N    = 3;
  localparam int unsigned CLR_OFS  = 1;
  localparam int unsigned LOCK_OFS = 2;

  localparam logic [31:0] RST_DEFAULT   = 32'h0000_FF0F;
  localparam logic [31:0] CLK_DEFAULT   = 32'hFFFF_0000;
  localparam logic [31:0] PLL_LOCK_MASK = 32'h8000_0000;
  localparam logic [31:0] LFSR_TAPS     = 32'h8020_0003;

  function automatic reg_kind_e kind_of(input int unsigned w);
    if (w == W_KEY) return RK_KEY;
    if (w == W_REV_A || w == W_REV_B || w == W_CHIP) return RK_RO;
    if (w == W_RAND) return RK_RAND;
    if (w == W_RST || w == W_CLK) return RK_SET;
    if (w == W_RST + CLR_OFS || w == W_CLK + CLR_OFS) return RK_CLR;
    if (w == W_STRAP0 || w == W_STRAP1) return RK_STRAP;
    if (w == W_STRAP0 + CLR_OFS || w == W_STRAP1 + CLR_OFS) return RK_STRAP_CLR;
    if (w >= W_PLL0 && w < W_PLL0 + PLL_N) return RK_PLL;
    return RK_PLAIN;
  endfunction

  function automatic logic [31:0] default_of(input int unsigned w, input logic [31:0] chip);
    if (w == W_CHIP) return chip;
    if (w == W_RST) return RST_DEFAULT;
    if (w == W_CLK) return CLK_DEFAULT;
    return 32'h0;
  endfunction

  // Set-type update: OR on the set word, AND-NOT on its clear alias.
  function automatic logic [31:0] apply_set_clr(input logic [31:0] cur, input logic [31:0] data,
                                                input logic do_set, input logic do_clr);
    logic [31:0] v;
    v = cur;
    if (do_set) v = v | data;
    if (do_clr) v = v & ~data;
    return v;
  endfunction

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    logic [31:0] n;
    n = {1'b0, s[31:1]};
    for (int b = 0; b < 32; b++) begin
      if (LFSR_TAPS[b]) n[b] = n[b] ^ s[0];
    end
    return n;
  endfunction

endpackage

// File: rtl/keybank_decode.sv
module keybank_decode
  import keybank_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 6,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic [IDX_W-1:0]  idx,
  output reg_kind_e         kind
);
  always_comb begin
    in_range = (32'(addr) < 32'(NUM_REGS));
    idx      = addr[IDX_W-1:0];
    kind     = kind_of(32'(idx));
  end
endmodule

// File: rtl/keybank_lfsr.sv
module keybank_lfsr
  import keybank_pkg::*;
#(
  parameter logic [31:0] SEED = 32'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        advance,
  output logic [31:0] next_word
);
  logic [31:0] state_q;

  assign next_word = lfsr_step(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (advance) state_q <= next_word;
  end

  // R7: the sequence only moves on a read of the random word
  assert_lfsr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(state_q));
  // R7: the state never collapses to the all-zero lock-up value
  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (state_q != 32'h0));
endmodule

// File: rtl/key_ctrl_bank.sv
module key_ctrl_bank
  import keybank_pkg::*;
#(
  parameter int          NUM_REGS = 32,
  parameter int          ADDR_W   = 6,
  parameter logic [31:0] MAGIC    = 32'h1688_A8A8,
  parameter logic [31:0] CHIP_ID  = 32'h2A5C_0001,
  parameter logic [31:0] SEED     = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_init,
  input  logic [31:0]       rev_a_init,
  input  logic [31:0]       rev_b_init,
  input  logic [31:0]       strap0_init,
  input  logic [31:0]       strap1_init,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic             in_range;
  logic [IDX_W-1:0] idx;
  reg_kind_e        kind;
  logic [31:0]      regs_q [NUM_REGS];
  logic [31:0]      rand_word;
  logic [31:0]      rd_val;

  // Named events for the assertions
  logic unlocked, acc, wr_acc, wr_allowed, rd_ev, rand_rd, ro_wr, key_wr, locked_wr;

  keybank_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .in_range(in_range), .idx(idx), .kind(kind)
  );

  keybank_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .advance(rand_rd), .next_word(rand_word)
  );

  always_comb begin
    unlocked   = regs_q[W_KEY][0];
    acc        = req_valid && in_range;
    wr_acc     = acc && req_write;
    wr_allowed = wr_acc && (unlocked || idx == '0);
    rd_ev      = acc && !req_write;
    rand_rd    = rd_ev && kind == RK_RAND;
    ro_wr      = wr_acc && (kind == RK_RO || kind == RK_RAND);
    key_wr     = wr_allowed && kind == RK_KEY;
    locked_wr  = wr_acc && !unlocked && idx != '0;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    localparam reg_kind_e K = kind_of(g);
    logic [31:0] q, nxt, rst_val;
    logic        hit;

    assign hit = wr_allowed && (idx == IDX_W'(g));
    assign rst_val = (g == W_KEY)    ? {31'b0, key_init} :
                     (g == W_REV_A)  ? rev_a_init  :
                     (g == W_REV_B)  ? rev_b_init  :
                     (g == W_STRAP0) ? strap0_init :
                     (g == W_STRAP1) ? strap1_init : default_of(g, CHIP_ID);

    if (K == RK_KEY) begin : g_key
      assign nxt = hit ? {31'b0, req_wdata == MAGIC} : q;
    end else if (K == RK_SET) begin : g_set
      logic hit_clr;
      assign hit_clr = wr_allowed && (idx == IDX_W'(g + CLR_OFS));
      assign nxt = apply_set_clr(q, req_wdata, hit, hit_clr);
    end else if (K == RK_STRAP) begin : g_strap
      logic hit_clr, frozen;
      assign frozen  = regs_q[g + LOCK_OFS] != 32'h0;
      assign hit_clr = wr_allowed && (idx == IDX_W'(g + CLR_OFS));
      assign nxt = apply_set_clr(q, req_wdata, hit && !frozen, hit_clr);
    end else if (K == RK_PLAIN || K == RK_PLL) begin : g_store
      assign nxt = hit ? req_wdata : q;
    end else begin : g_hold
      assign nxt = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= rst_val;
      else        q <= nxt;
    end
    assign regs_q[g] = q;
  end

  always_comb begin
    rd_val = '0;
    if (in_range) begin
      case (kind)
        RK_PLL:               rd_val = regs_q[idx] | PLL_LOCK_MASK;
        RK_RAND:              rd_val = rand_word;
        RK_CLR, RK_STRAP_CLR: rd_val = '0;
        default:              rd_val = regs_q[idx];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_ev ? rd_val : '0;
      rsp_err   <= req_valid && (!in_range || ro_wr);
    end
  end

  // R1: key word follows the magic comparison of the written data
  assert_key_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (regs_q[W_KEY] == {31'b0, $past(req_wdata) == MAGIC}));
  // R2: a closed bank keeps the addressed word
  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked_wr |=> (regs_q[$past(idx)] == $past(regs_q[idx])));
  // R4: bits named in a clear-alias write are gone next cycle
  assert_clear_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_allowed && idx == IDX_W'(W_RST + CLR_OFS)) |=> ((regs_q[W_RST] & $past(req_wdata)) == 32'h0));
  // R5: a locked strap ignores set writes
  assert_strap_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_allowed && idx == IDX_W'(W_STRAP0) && regs_q[W_STRAP0 + LOCK_OFS] != 32'h0)
      |=> $stable(regs_q[W_STRAP0]));
  // R6: write to a read-only word flags an error
  assert_ro_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ro_wr |=> (rsp_valid && rsp_err));
  // R8: PLL reads always show the lock bit
  assert_pll_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && kind == RK_PLL) |=> rsp_rdata[31]);
  // R9: out-of-range access answers zero with an error
  assert_oor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_range) |=> (rsp_valid && rsp_err && rsp_rdata == 32'h0));
  // R11: a response appears only after a request
  assert_rsp_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

// File: tb/tb_key_ctrl_bank.sv
`timescale 1ns/1ps
module tb_key_ctrl_bank;
  localparam logic [31:0] MAGIC = 32'h1688_A8A8;
  localparam logic [31:0] SEED  = 32'h0000_0001;
  localparam logic [31:0] REV_A = 32'h0501_0303;
  localparam logic [31:0] REV_B = 32'h0601_0203;
  localparam int NV = 41;

  logic clk = 0, rst_n = 0, key_init = 0;
  logic [31:0] strap0_init = 32'h0000_00A5, strap1_init = 32'h0000_3C00;
  logic req_valid = 0, req_write = 0;
  logic [5:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  key_ctrl_bank dut (
    .clk(clk), .rst_n(rst_n), .key_init(key_init),
    .rev_a_init(REV_A), .rev_b_init(REV_B),
    .strap0_init(strap0_init), .strap1_init(strap1_init),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  // {req tag, write, addr, data, expected read, expected err}
  localparam logic [75:0] VEC [NV] = '{
    {4'd3,  1'b1, 6'd4,  32'h0000_00F0, 32'h0, 1'b0},          // R3 set
    {4'd3,  1'b0, 6'd4,  32'h0, 32'h0000_FFFF, 1'b0},
    {4'd4,  1'b1, 6'd5,  32'h0000_0F03, 32'h0, 1'b0},          // R4 clear
    {4'd4,  1'b0, 6'd4,  32'h0, 32'h0000_F0FC, 1'b0},
    {4'd4,  1'b0, 6'd5,  32'h0, 32'h0, 1'b0},
    {4'd3,  1'b1, 6'd6,  32'h0000_0011, 32'h0, 1'b0},
    {4'd3,  1'b0, 6'd6,  32'h0, 32'hFFFF_0011, 1'b0},
    {4'd4,  1'b1, 6'd7,  32'hFFFF_0000, 32'h0, 1'b0},
    {4'd4,  1'b0, 6'd6,  32'h0, 32'h0000_0011, 1'b0},
    {4'd5,  1'b1, 6'd8,  32'h0000_0100, 32'h0, 1'b0},          // R5 strap
    {4'd5,  1'b0, 6'd8,  32'h0, 32'h0000_01A5, 1'b0},
    {4'd5,  1'b1, 6'd9,  32'h0000_0005, 32'h0, 1'b0},
    {4'd5,  1'b0, 6'd8,  32'h0, 32'h0000_01A0, 1'b0},
    {4'd5,  1'b1, 6'd10, 32'h0000_0001, 32'h0, 1'b0},
    {4'd5,  1'b1, 6'd8,  32'h0000_F000, 32'h0, 1'b0},
    {4'd5,  1'b0, 6'd8,  32'h0, 32'h0000_01A0, 1'b0},
    {4'd5,  1'b1, 6'd9,  32'h0000_0020, 32'h0, 1'b0},
    {4'd5,  1'b0, 6'd8,  32'h0, 32'h0000_0180, 1'b0},
    {4'd5,  1'b0, 6'd10, 32'h0, 32'h0000_0001, 1'b0},
    {4'd5,  1'b0, 6'd12, 32'h0, 32'h0000_3C00, 1'b0},
    {4'd5,  1'b1, 6'd12, 32'h0000_0003, 32'h0, 1'b0},
    {4'd5,  1'b0, 6'd12, 32'h0, 32'h0000_3C03, 1'b0},
    {4'd6,  1'b1, 6'd1,  32'hFFFF_FFFF, 32'h0, 1'b1},          // R6 read-only
    {4'd6,  1'b0, 6'd1,  32'h0, 32'h0501_0303, 1'b0},
    {4'd6,  1'b1, 6'd2,  32'h0, 32'h0, 1'b1},
    {4'd6,  1'b0, 6'd2,  32'h0, 32'h0601_0203, 1'b0},
    {4'd6,  1'b1, 6'd3,  32'hFFFF_FFFF, 32'h0, 1'b1},
    {4'd6,  1'b0, 6'd3,  32'h0, 32'h2A5C_0001, 1'b0},
    {4'd8,  1'b1, 6'd16, 32'h0000_1234, 32'h0, 1'b0},          // R8 PLL
    {4'd8,  1'b0, 6'd16, 32'h0, 32'h8000_1234, 1'b0},
    {4'd8,  1'b1, 6'd17, 32'h8000_0000, 32'h0, 1'b0},
    {4'd8,  1'b0, 6'd17, 32'h0, 32'h8000_0000, 1'b0},
    {4'd8,  1'b0, 6'd18, 32'h0, 32'h8000_0000, 1'b0},
    {4'd12, 1'b1, 6'd11, 32'hCAFE_F00D, 32'h0, 1'b0},          // R12 plain
    {4'd12, 1'b0, 6'd11, 32'h0, 32'hCAFE_F00D, 1'b0},
    {4'd12, 1'b1, 6'd31, 32'h0000_0001, 32'h0, 1'b0},
    {4'd12, 1'b0, 6'd31, 32'h0, 32'h0000_0001, 1'b0},
    {4'd12, 1'b0, 6'd19, 32'h0, 32'h0, 1'b0},
    {4'd9,  1'b1, 6'd32, 32'h0000_0055, 32'h0, 1'b1},          // R9 range
    {4'd9,  1'b0, 6'd32, 32'h0, 32'h0, 1'b1},
    {4'd9,  1'b0, 6'd63, 32'h0, 32'h0, 1'b1}
  };

  function automatic logic [31:0] ref_step(input logic [31:0] s);
    return (s >> 1) ^ ({32{s[0]}} & 32'h8020_0003);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [5:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er, output logic vl);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er, vl;
    access(1'b0, a, 32'h0, rd, er, vl);
    check(tag, rd, exp);
  endtask

  task automatic wr_do(input logic [5:0] a, input logic [31:0] d, input logic exp_err);
    logic [31:0] rd; logic er, vl;
    access(1'b1, a, d, rd, er, vl);
    check("R11 write err flag", {31'b0, er}, {31'b0, exp_err});
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    logic [31:0] rd, lf; logic er, vl;
    do_reset();
    // R10 reset state
    rd_chk("R10 key reset", 6'd0, 32'h0);
    rd_chk("R10 rev_a", 6'd1, REV_A);
    rd_chk("R10 strap0", 6'd8, 32'h0000_00A5);
    rd_chk("R10 word4 default", 6'd4, 32'h0000_FF0F);
    rd_chk("R10 word6 default", 6'd6, 32'hFFFF_0000);
    rd_chk("R10 chip id", 6'd3, 32'h2A5C_0001);
    // R2 closed bank
    wr_do(6'd11, 32'h0000_DEAD, 1'b0);
    rd_chk("R2 locked plain", 6'd11, 32'h0);
    wr_do(6'd4, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R2 locked set", 6'd4, 32'h0000_FF0F);
    // R1 unlock
    wr_do(6'd0, 32'h1234_5678, 1'b0);
    rd_chk("R1 wrong key", 6'd0, 32'h0);
    wr_do(6'd0, MAGIC, 1'b0);
    rd_chk("R1 magic key", 6'd0, 32'h1);
    // R11 response timing
    access(1'b0, 6'd0, 32'h0, rd, er, vl);
    check("R11 rsp_valid after request", {31'b0, vl}, 32'h1);
    @(negedge clk);
    check("R11 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
    access(1'b1, 6'd11, 32'h0000_0042, rd, er, vl);
    check("R11 write rdata zero", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] t; logic w; logic [5:0] a; logic [31:0] d, e; logic ee;
      {t, w, a, d, e, ee} = VEC[i];
      access(w, a, d, rd, er, vl);
      check($sformatf("R%0d vec %0d valid", t, i), {31'b0, vl}, 32'h1);
      check($sformatf("R%0d vec %0d err", t, i), {31'b0, er}, {31'b0, ee});
      if (!w) check($sformatf("R%0d vec %0d data", t, i), rd, e);
    end

    // R7 random word
    lf = ref_step(SEED);
    rd_chk("R7 first random", 6'd15, lf);
    wr_do(6'd15, 32'hFFFF_FFFF, 1'b1);
    lf = ref_step(lf);
    rd_chk("R7 second random", 6'd15, lf);
    lf = ref_step(lf);
    rd_chk("R7 third random", 6'd15, lf);
    // R1 relock, then R2
    wr_do(6'd0, MAGIC + 32'h1, 1'b0);
    rd_chk("R1 relock", 6'd0, 32'h0);
    wr_do(6'd11, 32'h0000_0001, 1'b0);
    rd_chk("R2 relocked hold", 6'd11, 32'hCAFE_F00D);
    // R10 second reset with new port values
    key_init = 1; strap0_init = 32'h0000_005A;
    do_reset();
    rd_chk("R10 key from port", 6'd0, 32'h1);
    rd_chk("R10 strap0 from port", 6'd8, 32'h0000_005A);
    rd_chk("R10 plain cleared", 6'd11, 32'h0);
    rd_chk("R7 sequence restarts", 6'd15, ref_step(SEED));

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule